// File: doc/BRIEF.md
# Double-Precision Square Root Unit

This block computes the square root of one 64-bit IEEE-754 double-precision operand. It rounds the result to double precision in one of four rounding modes. It also maintains a small set of floating-point status bits. A caller raises `start_i` for one cycle while the unit is idle, together with the operand, the rounding mode, an invalid-operation enable and a record flag. The unit then shows `busy_o`. When the answer is ready it pulses `done_o` for one cycle, with `result_o` and a write-enable `wr_en_o` that says whether the target register should take the result.

Ordinary positive operands go through four steps. Subnormal inputs are pre-normalized first. The exponent is then made even. A radix-2 restoring digit recurrence produces 55 root bits, one bit per cycle, and the remainder supplies a sticky bit. A final rounding step adds the increment directly into the packed exponent and fraction. Zeros, infinities, NaNs and negative operands skip the recurrence and take a one-cycle path through a fixed table of special results.

Each operation updates the status registers on the clock edge that ends the `done_o` cycle:
- the result class code;
- the rounded and inexact flags of that operation;
- the sticky inexact, summary and invalid flags.

When the record flag was set, the same edge also copies a summary into a 4-bit condition field.

Top module: `fsq_sqrt_top`

## Requirements
- R1: A `start_i` pulse seen while `busy_o` is 0 starts one operation. `busy_o` stays 1 until `done_o` has been high. `done_o` is a single-cycle pulse. `result_o` and `wr_en_o` are valid while `done_o` is 1. Status outputs and `cond_o` show the new values from the cycle after `done_o`.
- R2: For a positive finite nonzero operand, normal or subnormal, `result_o` is the square root rounded per `rmode_i`, with a normalized significand. The encodings are: 00 nearest-even, 01 toward zero, 10 toward +infinity, 11 toward -infinity.
- R3: A negative infinity operand, or any negative finite nonzero operand, gives the default quiet NaN 0x7FF8000000000000 and sets `inv_neg_o`.
- R4: +0, -0 and +infinity are returned unchanged and raise no flag.
- R5: A signalling NaN (top fraction bit 51 = 0) returns its own bits with bit 51 set and sets `inv_snan_o`. A quiet NaN is returned unchanged with no flag.
- R6: `inexact_o` is 1 exactly when the rounded result differs from the exact root. `frac_rnd_o` is 1 exactly when rounding increased the magnitude. Both are 0 after special operands. `inx_sticky_o` is the OR of all `inexact_o` values since reset.
- R7: `cls_o` takes the class of the result: +normal 00100, +zero 00010, -zero 10010, +infinity 00101, quiet NaN 10001.
- R8: If `inv_en_i` was 1 for an operation that raised `inv_snan_o` or `inv_neg_o` behaviour, `wr_en_o` is 0 during `done_o` and `cls_o` keeps its previous value. Otherwise `wr_en_o` is 1.
- R9: `summary_o` is set whenever `inx_sticky_o`, `inv_snan_o` or `inv_neg_o` changes from 0 to 1. These four bits are cleared only by reset.
- R10: With `record_i` = 1, `cond_o` is loaded with {summary, enabled-invalid summary, invalid summary, overflow} from bit 3 down to bit 0. Here invalid summary = `inv_snan_o` | `inv_neg_o`, enabled-invalid summary = invalid summary & that operation's `inv_en_i`, and overflow is always 0. With `record_i` = 0, `cond_o` is unchanged.
- R11: After reset, `busy_o`, `done_o`, `cls_o`, all flags and `cond_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start an operation (taken when idle) |
| operand_i | input | 64 | Double-precision operand |
| rmode_i | input | 2 | Rounding mode |
| inv_en_i | input | 1 | Invalid-operation exception enable |
| record_i | input | 1 | Load the condition field on completion |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Result, valid with `done_o` |
| wr_en_o | output | 1 | Target register write enable, valid with `done_o` |
| cls_o | output | 5 | Result class and sign code |
| frac_rnd_o | output | 1 | Last result was rounded up in magnitude |
| inexact_o | output | 1 | Last result was inexact |
| inx_sticky_o | output | 1 | Sticky inexact |
| summary_o | output | 1 | Sticky exception summary |
| inv_snan_o | output | 1 | Sticky invalid: signalling NaN |
| inv_neg_o | output | 1 | Sticky invalid: root of a negative value |
| cond_o | output | 4 | Condition field |

## Verification
The bench targets several corner cases, each tied to the failure it would expose:
- Subnormal inputs down to the smallest one: a faulty pre-normalization gives a root that is off by a power of two.
- Odd and even exponents: a missed radix shift gives results off by a factor of about 1.41.
- Exact squares such as 4.0: a sticky bit that leaks gives false inexact or increment.
- The directed modes on irrational roots: a mode swap gives a result one unit in the last place wrong.

It also checks that an enabled invalid operation both drops the write and freezes the class code. Repeated exceptions are used to catch a summary bit that fires on every exception rather than only on a 0-to-1 change. Every root is checked against an exact integer bound, s² ≤ x < (s+1)², derived from a real-valued reference.

// File: rtl/fsq_pkg.sv
// Package: shared types and constants for the square root unit.
// Assumes IEEE-754 binary layout {sign, exponent, fraction}.
package fsq_pkg;

    typedef enum logic [1:0] {
        RM_NEAR = 2'b00,
        RM_ZERO = 2'b01,
        RM_PINF = 2'b10,
        RM_MINF = 2'b11
    } rmode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ROOT = 2'b01,
        ST_DONE = 2'b10
    } fsq_state_e;

    localparam logic [4:0] CLS_POS_NORM = 5'b00100;
    localparam logic [4:0] CLS_NEG_NORM = 5'b01000;
    localparam logic [4:0] CLS_POS_ZERO = 5'b00010;
    localparam logic [4:0] CLS_NEG_ZERO = 5'b10010;
    localparam logic [4:0] CLS_POS_INF  = 5'b00101;
    localparam logic [4:0] CLS_QNAN     = 5'b10001;

endpackage

// File: rtl/fsq_unpack.sv
// Module: fsq_unpack
// Purely combinational operand front end.
// - Classifies the operand and produces the special-case result, class and
//   invalid flags.
// - For ordinary positive operands it pre-normalizes subnormals, makes the
//   exponent even and outputs the radicand with the halved unbiased exponent.
// Assumes the operand is presented in the cycle it is accepted.
module fsq_unpack
    import fsq_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [EXP_W+FRAC_W:0]         opnd,
    output logic                          take_root,
    output logic [EXP_W+FRAC_W:0]         spec_res,
    output logic [4:0]                    spec_cls,
    output logic                          spec_snan,
    output logic                          spec_neg,
    output logic [FRAC_W+1:0]             rad,
    output logic signed [EXP_W+1:0]       rexp
);
    localparam int W    = 1 + EXP_W + FRAC_W;
    localparam int EW   = EXP_W + 2;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;
    localparam int LZW  = $clog2(FRAC_W + 1);
    localparam logic [W-1:0] DEF_QNAN =
        {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic               sgn;
    logic [EXP_W-1:0]   efld;
    logic [FRAC_W-1:0]  frc;
    logic               e_max, e_zero, f_zero, is_nan, is_zero, is_inf;
    logic [LZW-1:0]     lz;
    logic               found;
    logic [FRAC_W:0]    mant;
    logic signed [EW-1:0] e_unb, e_even;

    assign sgn     = opnd[W-1];
    assign efld    = opnd[W-2:FRAC_W];
    assign frc     = opnd[FRAC_W-1:0];
    assign e_max   = &efld;
    assign e_zero  = ~|efld;
    assign f_zero  = ~|frc;
    assign is_nan  = e_max & ~f_zero;
    assign is_inf  = e_max & f_zero;
    assign is_zero = e_zero & f_zero;

    // Special-operand table: result, class and invalid flags.
    always_comb begin
        take_root = 1'b0;
        spec_res  = opnd;
        spec_cls  = CLS_POS_NORM;
        spec_snan = 1'b0;
        spec_neg  = 1'b0;
        if (is_nan) begin
            spec_res  = opnd | (W'(1) << (FRAC_W - 1));
            spec_cls  = CLS_QNAN;
            spec_snan = ~frc[FRAC_W-1];
        end else if (is_zero) begin
            spec_cls  = sgn ? CLS_NEG_ZERO : CLS_POS_ZERO;
        end else if (sgn) begin
            spec_res  = DEF_QNAN;
            spec_cls  = CLS_QNAN;
            spec_neg  = 1'b1;
        end else if (is_inf) begin
            spec_cls  = CLS_POS_INF;
        end else begin
            take_root = 1'b1;
        end
    end

    // Leading-zero count of the fraction for subnormal pre-normalization.
    always_comb begin
        lz    = '0;
        found = 1'b0;
        for (int i = FRAC_W - 1; i >= 0; i--) begin
            if (!found && frc[i]) begin
                lz    = LZW'(FRAC_W - 1 - i);
                found = 1'b1;
            end
        end
    end

    // Significand with explicit leading one and its unbiased exponent.
    always_comb begin
        if (e_zero) begin
            mant  = {frc, 1'b0} << lz;
            e_unb = EW'(-BIAS) - EW'(lz);
        end else begin
            mant  = {1'b1, frc};
            e_unb = $signed({2'b00, efld}) - EW'(BIAS);
        end
    end

    // Even-exponent adjustment and radicand alignment.
    always_comb begin
        rad    = e_unb[0] ? {mant, 1'b0} : {1'b0, mant};
        e_even = e_unb - EW'(e_unb[0]);
        rexp   = e_even >>> 1;
    end

endmodule

// File: rtl/fsq_root.sv
// Module: fsq_root
// Radix-2 restoring square root of a fixed-point radicand.
// - Produces QW root bits, one per cycle, after a load pulse.
// - Raises fin for one cycle when the root and the remainder are final.
// Assumes the radicand lies in [1,4) with FRAC_W fraction bits, so the root
// has a leading one.
module fsq_root #(
    parameter int FRAC_W = 52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [FRAC_W+1:0] rad,
    output logic [FRAC_W+2:0] q,
    output logic              sticky,
    output logic              fin
);
    localparam int QW   = FRAC_W + 3;
    localparam int SW   = 2 * QW;
    localparam int PADW = SW - (FRAC_W + 2);
    localparam int CW   = $clog2(QW + 1);

    logic [SW-1:0]   sr;
    logic [QW+1:0]   rem;
    logic [QW+1:0]   rem_sh, trial;
    logic [CW-1:0]   cnt;
    logic            active;
    logic            ge;

    assign rem_sh = {rem[QW-1:0], sr[SW-1 -: 2]};
    assign trial  = {q, 2'b01};
    assign ge     = (rem_sh >= trial);
    assign sticky = |rem;

    // One restoring step per cycle while active.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr     <= '0;
            rem    <= '0;
            q      <= '0;
            cnt    <= '0;
            active <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (load) begin
                sr     <= {rad, PADW'(0)};
                rem    <= '0;
                q      <= '0;
                cnt    <= '0;
                active <= 1'b1;
            end else if (active) begin
                rem <= ge ? (rem_sh - trial) : rem_sh;
                q   <= {q[QW-2:0], ge};
                sr  <= sr << 2;
                cnt <= cnt + 1'b1;
                if (cnt == CW'(QW - 1)) begin
                    active <= 1'b0;
                    fin    <= 1'b1;
                end
            end
        end
    end

    AST_ROOT_LEAD_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> q[QW-1]); // R2
    AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (rem <= {1'b0, q, 1'b0})); // R2

endmodule

// File: rtl/fsq_round.sv
// Module: fsq_round
// Rounds a QW-bit root (leading one, guard and round bits, plus a sticky bit)
// to the packed double format. The increment is added into the packed
// exponent and fraction, so a carry out of the fraction bumps the exponent.
// Assumes a positive result (the sign is always 0).
module fsq_round
    import fsq_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic [FRAC_W+2:0]        q,
    input  logic                     sticky,
    input  logic signed [EXP_W+1:0]  rexp,
    input  logic [1:0]               rm,
    output logic [EXP_W+FRAC_W:0]    res,
    output logic                     inexact,
    output logic                     up
);
    localparam int W    = 1 + EXP_W + FRAC_W;
    localparam int EW   = EXP_W + 2;
    localparam int BIAS = (1 << (EXP_W - 1)) - 1;

    logic          guard, tail, lsb;
    logic [EW-1:0] biased;

    assign guard   = q[1];
    assign tail    = q[0] | sticky;
    assign lsb     = q[2];
    assign inexact = guard | tail;
    assign biased  = rexp + EW'(BIAS);

    // Increment decision per rounding mode.
    always_comb begin
        case (rmode_e'(rm))
            RM_NEAR: up = guard & (tail | lsb);
            RM_PINF: up = guard | tail;
            default: up = 1'b0;
        endcase
    end

    // Pack and add the increment.
    assign res = {1'b0, biased[EXP_W-1:0], q[FRAC_W+1:2]} + W'(up);

endmodule

// File: rtl/fsq_sqrt_top.sv
// Module: fsq_sqrt_top
// Double-precision square root with start/busy/done handshake and status.
// - Special operands finish in one cycle; others run the digit recurrence.
// - Status and condition registers update on the edge that ends done.
// Assumes start is only honoured while idle.
module fsq_sqrt_top
    import fsq_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start_i,
    input  logic [EXP_W+FRAC_W:0]     operand_i,
    input  logic [1:0]                rmode_i,
    input  logic                      inv_en_i,
    input  logic                      record_i,
    output logic                      busy_o,
    output logic                      done_o,
    output logic [EXP_W+FRAC_W:0]     result_o,
    output logic                      wr_en_o,
    output logic [4:0]                cls_o,
    output logic                      frac_rnd_o,
    output logic                      inexact_o,
    output logic                      inx_sticky_o,
    output logic                      summary_o,
    output logic                      inv_snan_o,
    output logic                      inv_neg_o,
    output logic [3:0]                cond_o
);
    localparam int W  = 1 + EXP_W + FRAC_W;
    localparam int QW = FRAC_W + 3;
    localparam int EW = EXP_W + 2;

    fsq_state_e          st;
    logic                take_root, spec_snan, spec_neg;
    logic [W-1:0]        spec_res, rnd_res, res_q;
    logic [4:0]          spec_cls, cls_q;
    logic [FRAC_W+1:0]   rad;
    logic signed [EW-1:0] rexp, rexp_q;
    logic [QW-1:0]       root_q;
    logic                root_sticky, root_fin, root_load;
    logic                rnd_inx, rnd_up;
    logic [1:0]          rm_q;
    logic                ie_q, rec_q, snan_q, neg_q, fi_q, fr_q;
    logic                invalid, xx_nxt, vs_nxt, vn_nxt, fx_nxt;

    fsq_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) unpack_i (
        .opnd(operand_i), .take_root(take_root), .spec_res(spec_res),
        .spec_cls(spec_cls), .spec_snan(spec_snan), .spec_neg(spec_neg),
        .rad(rad), .rexp(rexp)
    );

    assign root_load = (st == ST_IDLE) && start_i && take_root;

    fsq_root #(.FRAC_W(FRAC_W)) root_i (
        .clk(clk), .rst_n(rst_n), .load(root_load), .rad(rad),
        .q(root_q), .sticky(root_sticky), .fin(root_fin)
    );

    fsq_round #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) round_i (
        .q(root_q), .sticky(root_sticky), .rexp(rexp_q), .rm(rm_q),
        .res(rnd_res), .inexact(rnd_inx), .up(rnd_up)
    );

    // Operation sequencer: accept, iterate or bypass, then present the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= ST_IDLE;
            res_q  <= '0;
            cls_q  <= '0;
            rexp_q <= '0;
            rm_q   <= '0;
            ie_q   <= 1'b0;
            rec_q  <= 1'b0;
            snan_q <= 1'b0;
            neg_q  <= 1'b0;
            fi_q   <= 1'b0;
            fr_q   <= 1'b0;
        end else begin
            case (st)
                ST_IDLE: if (start_i) begin
                    ie_q   <= inv_en_i;
                    rec_q  <= record_i;
                    rm_q   <= rmode_i;
                    rexp_q <= rexp;
                    snan_q <= spec_snan;
                    neg_q  <= spec_neg;
                    res_q  <= spec_res;
                    cls_q  <= spec_cls;
                    fi_q   <= 1'b0;
                    fr_q   <= 1'b0;
                    st     <= take_root ? ST_ROOT : ST_DONE;
                end
                ST_ROOT: if (root_fin) begin
                    res_q <= rnd_res;
                    fi_q  <= rnd_inx;
                    fr_q  <= rnd_up;
                    cls_q <= CLS_POS_NORM;
                    st    <= ST_DONE;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    assign busy_o   = (st != ST_IDLE);
    assign done_o   = (st == ST_DONE);
    assign result_o = res_q;
    assign invalid  = snan_q | neg_q;
    assign wr_en_o  = done_o & ~(ie_q & invalid);

    // Next values of the sticky status bits for the finishing operation.
    always_comb begin
        xx_nxt = inx_sticky_o | fi_q;
        vs_nxt = inv_snan_o | snan_q;
        vn_nxt = inv_neg_o | neg_q;
        fx_nxt = summary_o | (fi_q & ~inx_sticky_o)
               | (snan_q & ~inv_snan_o) | (neg_q & ~inv_neg_o);
    end

    // Status and condition registers, written as done ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cls_o        <= '0;
            frac_rnd_o   <= 1'b0;
            inexact_o    <= 1'b0;
            inx_sticky_o <= 1'b0;
            summary_o    <= 1'b0;
            inv_snan_o   <= 1'b0;
            inv_neg_o    <= 1'b0;
            cond_o       <= '0;
        end else if (done_o) begin
            frac_rnd_o   <= fr_q;
            inexact_o    <= fi_q;
            inx_sticky_o <= xx_nxt;
            summary_o    <= fx_nxt;
            inv_snan_o   <= vs_nxt;
            inv_neg_o    <= vn_nxt;
            if (!(ie_q && invalid)) cls_o <= cls_q;
            if (rec_q) cond_o <= {fx_nxt, (vs_nxt | vn_nxt) & ie_q, vs_nxt | vn_nxt, 1'b0};
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R1
    AST_BUSY_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o); // R1
    AST_DEFAULT_QNAN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && neg_q) |-> (result_o == {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}})); // R3
    AST_CLS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !wr_en_o) |=> $stable(cls_o)); // R8
    AST_SUMMARY_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        summary_o |=> summary_o); // R9
    AST_INEXACT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        inx_sticky_o |=> inx_sticky_o); // R9
    AST_COND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && rec_q) |=> $stable(cond_o)); // R10

endmodule

// File: tb/fsq_sqrt_top_tb_top.sv
`timescale 1ns/1ps
module fsq_sqrt_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] operand_i = '0;
    logic [1:0]  rmode_i = '0;
    logic        inv_en_i = 1'b0;
    logic        record_i = 1'b0;
    logic        busy_o, done_o, wr_en_o;
    logic [63:0] result_o;
    logic [4:0]  cls_o;
    logic        frac_rnd_o, inexact_o, inx_sticky_o, summary_o, inv_snan_o, inv_neg_o;
    logic [3:0]  cond_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // model of status state
    logic [4:0] m_cls = '0;
    logic       m_xx = 0, m_fx = 0, m_vs = 0, m_vn = 0;
    logic [3:0] m_cond = '0;

    always #2 clk = ~clk;

    fsq_sqrt_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .operand_i(operand_i),
        .rmode_i(rmode_i), .inv_en_i(inv_en_i), .record_i(record_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o), .wr_en_o(wr_en_o),
        .cls_o(cls_o), .frac_rnd_o(frac_rnd_o), .inexact_o(inexact_o),
        .inx_sticky_o(inx_sticky_o), .summary_o(summary_o),
        .inv_snan_o(inv_snan_o), .inv_neg_o(inv_neg_o), .cond_o(cond_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    // Exact reference root for a positive finite nonzero operand.
    function automatic void ref_root(input logic [63:0] a, input logic [1:0] rm,
                                     output logic [63:0] r, output bit fi, output bit fr);
        logic [63:0]  qn, lo, hi;
        logic [52:0]  m, s;
        logic [127:0] lhs, rhs;
        int           e, er, d;
        qn = $realtobits($sqrt($bitstoreal(a)));
        if (a[62:52] == 0) begin
            m = {1'b0, a[51:0]};
            e = -1022;
            while (!m[52]) begin m = m << 1; e--; end
        end else begin
            m = {1'b1, a[51:0]};
            e = int'(a[62:52]) - 1023;
        end
        s   = {1'b1, qn[51:0]};
        er  = int'(qn[62:52]) - 1023;
        d   = e + 52 - 2 * er;
        lhs = 128'(s) * 128'(s);
        rhs = 128'(m) << d;
        if (lhs > rhs) begin lo = qn - 1; hi = qn; end
        else begin lo = qn; hi = qn + 1; end
        fi = (lhs != rhs);
        case (rm)
            2'b00: r = qn;
            2'b10: r = fi ? hi : qn;
            default: r = fi ? lo : qn;
        endcase
        fr = fi && (r == hi);
    endfunction

    task automatic run_op(input logic [63:0] a, input logic [1:0] rm,
                          input logic ie, input logic rec);
        logic [63:0] e_res;
        logic [4:0]  e_cls;
        bit          e_fi, e_fr, e_sn, e_ng, e_wr, nan, zero;
        string       tag;
        int          guard;
        e_fi = 0; e_fr = 0; e_sn = 0; e_ng = 0;
        nan  = (a[62:52] == 11'h7FF) && (a[51:0] != 0);
        zero = (a[62:0] == 0);
        if (nan) begin
            e_sn = !a[51]; e_res = a | 64'h0008_0000_0000_0000; e_cls = 5'b10001; tag = "R5";
        end else if (zero) begin
            e_res = a; e_cls = a[63] ? 5'b10010 : 5'b00010; tag = "R4";
        end else if (a[63]) begin
            e_ng = 1; e_res = 64'h7FF8_0000_0000_0000; e_cls = 5'b10001; tag = "R3";
        end else if (a[62:52] == 11'h7FF) begin
            e_res = a; e_cls = 5'b00101; tag = "R4";
        end else begin
            ref_root(a, rm, e_res, e_fi, e_fr); e_cls = 5'b00100; tag = "R2";
        end
        e_wr = !(ie && (e_sn || e_ng));

        @(negedge clk);
        while (busy_o) @(negedge clk);
        operand_i = a; rmode_i = rm; inv_en_i = ie; record_i = rec; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R1", "busy after start", 64'(busy_o), 64'(1));
        guard = 0;
        while (!done_o && guard < 200) begin @(negedge clk); guard++; end
        chk("R1", "done seen", 64'(done_o), 64'(1));
        chk("R8", "wr_en", 64'(wr_en_o), 64'(e_wr));
        if (e_wr) chk(tag, $sformatf("result of %h mode %0d", a, rm), result_o, e_res);

        // model update (R6, R7, R8, R9, R10)
        m_fx = m_fx | (e_fi & ~m_xx) | (e_sn & ~m_vs) | (e_ng & ~m_vn);
        m_xx = m_xx | e_fi;
        m_vs = m_vs | e_sn;
        m_vn = m_vn | e_ng;
        if (e_wr) m_cls = e_cls;
        if (rec) m_cond = {m_fx, (m_vs | m_vn) & ie, m_vs | m_vn, 1'b0};

        @(negedge clk);
        chk("R1", "done single pulse", 64'(done_o), 64'(0));
        chk(e_wr ? "R7" : "R8", "class code", 64'(cls_o), 64'(m_cls));
        chk("R6", "inexact", 64'(inexact_o), 64'(e_fi));
        chk("R6", "frac rounded", 64'(frac_rnd_o), 64'(e_fr));
        chk("R6", "inexact sticky", 64'(inx_sticky_o), 64'(m_xx));
        chk("R9", "summary", 64'(summary_o), 64'(m_fx));
        chk("R5", "invalid snan", 64'(inv_snan_o), 64'(m_vs));
        chk("R3", "invalid negative", 64'(inv_neg_o), 64'(m_vn));
        chk("R10", "cond field", 64'(cond_o), 64'(m_cond));
    endtask

    function automatic logic [63:0] rnd64();
        return {$urandom, $urandom};
    endfunction

    function automatic logic [63:0] pick_special(input int k);
        case (k % 9)
            0: return 64'h0000_0000_0000_0000;
            1: return 64'h8000_0000_0000_0000;
            2: return 64'h7FF0_0000_0000_0000;
            3: return 64'hFFF0_0000_0000_0000;
            4: return {1'b1, rnd64() >> 1};
            5: return 64'h7FF0_0000_0000_0000 | (rnd64() & 64'h0007_FFFF_FFFF_FFFF) | 64'h1;
            6: return 64'h7FF8_0000_0000_0000 | (rnd64() & 64'h8007_FFFF_FFFF_FFFF);
            7: return 64'h8000_0000_0000_0001;
            default: return 64'h0000_0000_0000_0001;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] a;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11", "busy", 64'(busy_o), 64'(0));
        chk("R11", "done", 64'(done_o), 64'(0));
        chk("R11", "class", 64'(cls_o), 64'(0));
        chk("R11", "flags", 64'({frac_rnd_o, inexact_o, inx_sticky_o, summary_o, inv_snan_o, inv_neg_o}), 64'(0));
        chk("R11", "cond", 64'(cond_o), 64'(0));

        // Directed corners: R2 exact, modes, subnormals, extremes
        run_op(64'h4010_0000_0000_0000, 2'b00, 0, 1);
        for (int m = 0; m < 4; m++) run_op(64'h4000_0000_0000_0000, 2'(m), 0, 0);
        for (int m = 0; m < 4; m++) run_op(64'h0000_0000_0000_0001, 2'(m), 0, 0);
        for (int m = 0; m < 4; m++) run_op(64'h000F_FFFF_FFFF_FFFF, 2'(m), 0, 0);
        for (int m = 0; m < 4; m++) run_op(64'h7FEF_FFFF_FFFF_FFFF, 2'(m), 0, 0);
        run_op(64'h3FEF_FFFF_FFFF_FFFF, 2'b10, 0, 1);
        // R4 pass-through specials
        run_op(64'h0000_0000_0000_0000, 2'b00, 0, 0);
        run_op(64'h8000_0000_0000_0000, 2'b11, 0, 0);
        run_op(64'h7FF0_0000_0000_0000, 2'b01, 0, 1);
        // R3, R8 invalid negatives, enabled and not
        run_op(64'hBFF0_0000_0000_0000, 2'b00, 0, 1);
        run_op(64'hFFF0_0000_0000_0000, 2'b00, 1, 1);
        run_op(64'h8000_0000_0000_0001, 2'b00, 1, 0);
        // R5 NaNs
        run_op(64'h7FF0_0000_0000_0001, 2'b00, 0, 1);
        run_op(64'hFFF4_0000_0000_0000, 2'b00, 1, 1);
        run_op(64'hFFF8_0000_0000_0123, 2'b00, 0, 1);

        // Constrained random mix
        for (int i = 0; i < 400; i++) begin
            int k;
            k = int'($urandom % 10);
            if (k == 0) a = pick_special(int'($urandom % 1000));
            else if (k == 1) a = {12'h000, rnd64() >> 12};
            else a = {1'b0, 11'($urandom % 2047), rnd64() >> 12};
            if (a == 64'h0) a = 64'h1;
            run_op(a, 2'($urandom), 1'($urandom), 1'($urandom));
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule